// File: doc/BRIEF.md
# Entropy Reseed Scheduler

This block decides when a pseudo-random generator must be reseeded and keeps watch over the reseed handshake with an external entropy source. A reseed can be started in two ways. Software can pulse a request command. A counter of completed keyed hash operations can also reach a programmable threshold. Only one request is in flight at a time. The block holds `req_o` high until the source answers on `ack_i`.

A two-level timer bounds each request. A 10-bit prescaler divides the clock into ticks, and a 16-bit wait timer counts those ticks against a wait limit. If the limit is reached before the answer arrives, the block moves into a sticky failure state and raises `timeout_o`. A limit of zero turns the timeout off. The completed-hash count is visible at all times on `hash_cnt_o`, and software can clear it by command.

Top module: `entropy_reseed_sched`

## Requirements
- R1: After reset, `req_o` is 0, `timeout_o` is 0 and `hash_cnt_o` is 0.
- R2: When no request is pending, a 1 on `sw_req_i` makes `req_o` go to 1 after the next clock edge. `req_o` stays 1 until a cycle in which `ack_i` is 1, and goes back to 0 after that edge.
- R3: The prescaler produces one tick every `prescale_i`+1 cycles, and the wait timer advances once per tick. With a captured wait limit L that is not zero, no acknowledge and prescale value p, `req_o` stays 1 for exactly L*(p+1)+1 cycles. After that, `req_o` is 0 and `timeout_o` is 1.
- R4: A captured wait limit of 0 disables the timeout. The request then stays pending for any number of cycles until it is acknowledged.
- R5: The wait limit is captured on the edge at which a request is issued. Changes to `wait_limit_i` while that request is pending have no effect on it, and take effect for the next request.
- R6: The prescaler count and the wait timer both restart from 0 at every new request. Time spent on an earlier request does not shorten a later one.
- R7: The failure state is held until reset. While in it, `timeout_o` stays 1, and `req_o` stays 0 whatever happens on `sw_req_i`, `ack_i` or the hash counter.
- R8: Each cycle with `hash_done_i` at 1 increments `hash_cnt_o` by one after the edge. The count saturates at 1023.
- R9: While `threshold_i` is not zero and the count is greater than or equal to it, the next edge clears the count to 0 and issues a request if none is pending. This also holds when the threshold is lowered below a count that has already been reached.
- R10: A `threshold_i` of 0 disables automatic refresh. A 1 on `sw_clr_i` clears the count at the next edge, and the clear wins over a `hash_done_i` in the same cycle.
- R11: Triggers that arrive while a request is pending are merged into it, so no second request follows its acknowledge. An `ack_i` while nothing is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prescale_i | input | 10 | Prescaler compare value; one tick per value+1 cycles |
| wait_limit_i | input | 16 | Wait limit in ticks; 0 means wait forever |
| threshold_i | input | 10 | Completed-hash refresh threshold; 0 disables |
| sw_req_i | input | 1 | Software reseed request command |
| sw_clr_i | input | 1 | Software clear command for the hash counter |
| hash_done_i | input | 1 | One pulse per completed keyed hash |
| req_o | output | 1 | Reseed request to the entropy source |
| ack_i | input | 1 | Acknowledge from the entropy source |
| timeout_o | output | 1 | Sticky timeout failure indication |
| hash_cnt_o | output | 10 | Current completed-hash count |

## Verification
Every result of this block lies one register stage behind its cause. A request command, a threshold hit, an acknowledge or a counter update is visible on the ports after exactly one rising edge, and the timeout appears L*(p+1)+1 cycles after the request first shows. The bench drives all inputs just after a falling edge and samples just after the next falling edge, so each sample sees exactly the edges it expects. Timeout checks count the falling edges on which `req_o` is high and compare that count with the closed-form length.

// File: rtl/ers_pkg.sv
package ers_pkg;

    // Request supervisor states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_FAIL = 2'd2
    } ers_state_e;

    typedef struct packed {
        ers_state_e state;
    } ers_ctrl_t;

endpackage

// File: rtl/ers_tick_gen.sv
// Clock-cycle prescaler: one tick each time the count reaches the compare value.
module ers_tick_gen #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         run_i,
    input  logic [W-1:0] cmp_i,
    output logic         tick_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (start_i) begin
            pc_d = '0;
        end else if (run_i) begin
            if (pc_q == cmp_i) pc_d = '0;
            else               pc_d = pc_q + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pc_q <= '0;
        else         pc_q <= pc_d;
    end

    assign tick_o = run_i && !start_i && (pc_q == cmp_i);

    // Between ticks the prescaler advances by exactly one per cycle
    assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !start_i && !tick_o) |=> (pc_q == $past(pc_q) + ONE));

    // A tick returns the prescaler to zero
    assert_tick_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (pc_q == '0));

endmodule

// File: rtl/ers_wait_timer.sv
// Tick counter compared against a limit captured when a request is issued.
module ers_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         pend_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_cfg_i,
    output logic         expire_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] TMAX = '1;

    logic [W-1:0] tm_d, tm_q;
    logic [W-1:0] lim_d, lim_q;

    always_comb begin
        tm_d  = tm_q;
        lim_d = lim_q;
        // The limit follows the input only while nothing is pending
        if (!pend_i) lim_d = limit_cfg_i;
        if (start_i) begin
            tm_d = '0;
        end else if (pend_i && tick_i && (tm_q != TMAX)) begin
            tm_d = tm_q + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tm_q  <= '0;
            lim_q <= '0;
        end else begin
            tm_q  <= tm_d;
            lim_q <= lim_d;
        end
    end

    assign expire_o = pend_i && (lim_q != '0) && (tm_q == lim_q);

    // Captured limit is frozen for the whole life of a request
    assert_limit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i && $past(pend_i)) |-> $stable(lim_q));

    // Wait timer advances one step per tick while pending
    assert_timer_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i && tick_i && !start_i && (tm_q != TMAX)) |=> (tm_q == $past(tm_q) + ONE));

endmodule

// File: rtl/ers_hash_counter.sv
// Saturating completed-hash counter with threshold compare and clear.
module ers_hash_counter #(
    parameter int W = 10
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic [W-1:0] thr_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    assign hit_o = (thr_i != '0) && (cnt_q >= thr_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || hit_o) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CMAX)) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && !hit_o && (cnt_q != CMAX)) |=> (cnt_q == $past(cnt_q) + ONE));

    assert_count_saturate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt_q == CMAX) && !clr_i && !hit_o) |=> (cnt_q == CMAX));

    assert_count_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/entropy_reseed_sched.sv
module entropy_reseed_sched
    import ers_pkg::*;
#(
    parameter int PRESCALE_W = 10,
    parameter int TIMER_W    = 16,
    parameter int CNT_W      = 10
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [PRESCALE_W-1:0] prescale_i,
    input  logic [TIMER_W-1:0]    wait_limit_i,
    input  logic [CNT_W-1:0]      threshold_i,
    input  logic                  sw_req_i,
    input  logic                  sw_clr_i,
    input  logic                  hash_done_i,
    output logic                  req_o,
    input  logic                  ack_i,
    output logic                  timeout_o,
    output logic [CNT_W-1:0]      hash_cnt_o
);
    ers_ctrl_t ctrl_d, ctrl_q;

    logic refresh_hit;
    logic trigger;
    logic issue;
    logic pending;
    logic tick;
    logic expire;

    assign pending = (ctrl_q.state == ST_WAIT);
    assign trigger = sw_req_i || refresh_hit;
    assign issue   = (ctrl_q.state == ST_IDLE) && trigger;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.state)
            ST_IDLE: if (trigger) ctrl_d.state = ST_WAIT;
            ST_WAIT: begin
                // An acknowledge wins over a timeout in the same cycle
                if (ack_i)       ctrl_d.state = ST_IDLE;
                else if (expire) ctrl_d.state = ST_FAIL;
            end
            ST_FAIL: ctrl_d.state = ST_FAIL;
            default: ctrl_d.state = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '{state: ST_IDLE};
        else         ctrl_q <= ctrl_d;
    end

    ers_tick_gen #(.W(PRESCALE_W)) i_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(issue),
        .run_i  (pending),
        .cmp_i  (prescale_i),
        .tick_o (tick)
    );

    ers_wait_timer #(.W(TIMER_W)) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (issue),
        .pend_i     (pending),
        .tick_i     (tick),
        .limit_cfg_i(wait_limit_i),
        .expire_o   (expire)
    );

    ers_hash_counter #(.W(CNT_W)) i_count (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (hash_done_i),
        .clr_i (sw_clr_i),
        .thr_i (threshold_i),
        .cnt_o (hash_cnt_o),
        .hit_o (refresh_hit)
    );

    assign req_o     = pending;
    assign timeout_o = (ctrl_q.state == ST_FAIL);

    assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> (timeout_o && !req_o));

    assert_ack_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && ack_i) |=> !req_o);

    assert_sw_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && !timeout_o && sw_req_i) |=> req_o);

    assert_refresh_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && !timeout_o && refresh_hit) |=> (req_o && (hash_cnt_o == '0)));

endmodule

// File: tb/test_entropy_reseed_sched.sv
module test_entropy_reseed_sched;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  prescale;
    logic [15:0] wait_limit;
    logic [9:0]  threshold;
    logic        sw_req, sw_clr, hash_done, ack;
    logic        req, timeout;
    logic [9:0]  hash_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    entropy_reseed_sched i_entropy_reseed_sched (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .prescale_i  (prescale),
        .wait_limit_i(wait_limit),
        .threshold_i (threshold),
        .sw_req_i    (sw_req),
        .sw_clr_i    (sw_clr),
        .hash_done_i (hash_done),
        .req_o       (req),
        .ack_i       (ack),
        .timeout_o   (timeout),
        .hash_cnt_o  (hash_cnt)
    );

    // {prescale, wait limit, expected cycles with req high} = L*(p+1)+1
    localparam logic [41:0] VEC [7] = '{
        {10'd0,    16'd1, 16'd2},
        {10'd0,    16'd5, 16'd6},
        {10'd3,    16'd2, 16'd9},
        {10'd1,    16'd4, 16'd9},
        {10'd9,    16'd3, 16'd31},
        {10'd2,    16'd7, 16'd22},
        {10'd1023, 16'd1, 16'd1025}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        prescale = '0; wait_limit = '0; threshold = '0;
        sw_req = 0; sw_clr = 0; hash_done = 0; ack = 0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_req;
        sw_req = 1'b1; cyc(1); sw_req = 1'b0;
    endtask

    task automatic pulse_ack;
        ack = 1'b1; cyc(1); ack = 1'b0;
    endtask

    // Issues a request and counts sampled cycles with req high
    task automatic run_until_drop(output int cnt);
        cnt = 0;
        sw_req = 1'b1;
        cyc(1);
        sw_req = 1'b0;
        while (req && cnt < 5000) begin
            cnt++;
            cyc(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        do_reset();
        // R1: reset state
        chk("R1 req", int'(req), 0);
        chk("R1 timeout", int'(timeout), 0);
        chk("R1 count", int'(hash_cnt), 0);

        // R3: timeout length table
        for (int v = 0; v < 7; v++) begin
            do_reset();
            prescale   = VEC[v][41:32];
            wait_limit = VEC[v][31:16];
            run_until_drop(cnt);
            chk("R3 req cycles", cnt, int'(VEC[v][15:0]));
            chk("R3 timeout", int'(timeout), 1);
        end

        // R4, R2, R11: limit zero waits forever; merged trigger; ack ends
        do_reset();
        prescale = 10'd0; wait_limit = 16'd0;
        pulse_req();
        chk("R2 req raised", int'(req), 1);
        cyc(300);
        chk("R4 still pending", int'(req), 1);
        chk("R4 no timeout", int'(timeout), 0);
        pulse_req();               // merged into pending request
        cyc(2);
        pulse_ack();
        chk("R2 ack drops req", int'(req), 0);
        cyc(5);
        chk("R11 no second request", int'(req), 0);
        pulse_ack();               // ack while idle
        chk("R11 idle ack ignored req", int'(req), 0);
        chk("R11 idle ack ignored timeout", int'(timeout), 0);

        // R5: limit change during pending is deferred
        do_reset();
        prescale = 10'd3; wait_limit = 16'd2;
        sw_req = 1'b1; cyc(1); sw_req = 1'b0;
        wait_limit = 16'd0;
        cnt = 0;
        while (req && cnt < 5000) begin cnt++; cyc(1); end
        chk("R5 change ignored cycles", cnt, 9);
        chk("R5 change ignored timeout", int'(timeout), 1);

        do_reset();
        prescale = 10'd0; wait_limit = 16'd0;
        pulse_req();
        wait_limit = 16'd1;
        cyc(50);
        chk("R5 zero limit kept", int'(timeout), 0);
        pulse_ack();
        run_until_drop(cnt);
        chk("R5 new limit next request", cnt, 2);
        chk("R5 new limit timeout", int'(timeout), 1);

        // R6: timers restart at each request
        do_reset();
        prescale = 10'd0; wait_limit = 16'd5;
        pulse_req();
        cyc(3);
        pulse_ack();
        cyc(2);
        run_until_drop(cnt);
        chk("R6 fresh timer", cnt, 6);

        // R7: failure is sticky (continuing from the timeout above)
        chk("R7 timeout set", int'(timeout), 1);
        pulse_req();
        pulse_ack();
        threshold = 10'd1;
        hash_done = 1'b1; cyc(1); hash_done = 1'b0;
        cyc(3);
        chk("R7 no request", int'(req), 0);
        chk("R7 timeout held", int'(timeout), 1);

        // R8: counting and saturation
        do_reset();
        hash_done = 1'b1; cyc(5); hash_done = 1'b0;
        chk("R8 count five", int'(hash_cnt), 5);
        hash_done = 1'b1; cyc(1030); hash_done = 1'b0;
        chk("R8 saturate", int'(hash_cnt), 1023);
        chk("R10 no auto request", int'(req), 0);

        // R10: clear beats increment
        sw_clr = 1'b1; hash_done = 1'b1; cyc(1);
        sw_clr = 1'b0; hash_done = 1'b0;
        chk("R10 clear", int'(hash_cnt), 0);

        // R9: threshold refresh
        do_reset();
        threshold = 10'd3; wait_limit = 16'd0;
        hash_done = 1'b1; cyc(3); hash_done = 1'b0;
        chk("R9 count at threshold", int'(hash_cnt), 3);
        chk("R9 no request yet", int'(req), 0);
        cyc(1);
        chk("R9 count cleared", int'(hash_cnt), 0);
        chk("R9 request issued", int'(req), 1);
        pulse_ack();

        // R9: lowering the threshold below the count (greater-or-equal)
        do_reset();
        threshold = 10'd0; wait_limit = 16'd0;
        hash_done = 1'b1; cyc(5); hash_done = 1'b0;
        chk("R9 count before", int'(hash_cnt), 5);
        threshold = 10'd2;
        cyc(1);
        chk("R9 ge request", int'(req), 1);
        chk("R9 ge cleared", int'(hash_cnt), 0);

        // R11: refresh during pending is merged
        threshold = 10'd1;
        hash_done = 1'b1; cyc(1); hash_done = 1'b0;
        cyc(2);
        chk("R11 count cleared while pending", int'(hash_cnt), 0);
        pulse_ack();
        cyc(4);
        chk("R11 merged refresh", int'(req), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule